// File: doc/BRIEF.md
# Block Address Translator

This block maps effective addresses onto physical addresses for large, contiguous regions of memory. It sits next to the normal paging path and is consulted in parallel with it. A small set of entries is held on chip. Each entry is written as two 32-bit words, an upper word and a lower word, through a simple write port. An entry describes one naturally aligned region of 128 KB to 256 MB, says which privilege levels may use it, where the region lands in physical memory, which cache attributes apply, and what kind of access is allowed.

For every lookup the caller presents an effective address, the privilege level and the access kind (read, write or instruction fetch). The block answers combinationally in the same cycle. It reports a hit with the physical address and the attribute bits, or it raises a protection fault, or it reports nothing when no entry covers the address. Only register writes are clocked.

Top module: `bat_xlate`

## Requirements
- R1: A synchronous active-low reset clears every entry, so no lookup hits or faults until entries are written again.
- R2: A write with `wr_hi`=1 loads the upper word of entry `wr_sel`: effective block index from bits [31:17], length mask from bits [12:2], supervisor-valid from bit 1 and user-valid from bit 0. A write with `wr_hi`=0 loads the lower word: physical block index from bits [31:17], attributes from bits [6:3] (write-through bit 6, cache-inhibit bit 5, coherence bit 4, guarded bit 3) and the protection code from bits [1:0].
- R3: An entry matches when address bits [31:17] equal its effective block index in every bit position not covered by the length mask. Mask bit k covers address bit 17+k. Mask 0x000 gives a 128 KB block, and mask 0x7FF gives a 256 MB block.
- R4: An entry can only match a user access (`user`=1) when its user-valid bit is set, and a supervisor access (`user`=0) when its supervisor-valid bit is set.
- R5: On a hit, physical address bits [31:17] take the effective address bit where the mask has a one and the physical block index bit where it has a zero. Bits [16:0] are copied unchanged from the effective address.
- R6: When several entries match, the lowest-numbered entry decides the result.
- R7: The access kind `acc` is encoded as 0 for read, 1 for write, 2 for fetch, and 3 is treated as a read. Protection code 0 denies every access. Code 1 denies writes only. Codes 2 and 3 allow every access. A denied access sets `fault` and clears `hit`, `pa` and `attr`.
- R8: On a hit, `attr` carries {write-through, cache-inhibit, coherence, guarded} from the deciding entry. On a fetch the guarded bit is reported as 0.
- R9: When no entry matches, `hit`, `fault`, `pa` and `attr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Entry number to write |
| wr_hi | input | 1 | 1 selects the upper word, 0 selects the lower word |
| wr_data | input | 32 | Register write data |
| ea | input | 32 | Effective address to translate |
| user | input | 1 | 1 for a user-level access, 0 for supervisor |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| hit | output | 1 | A permitted translation was found |
| fault | output | 1 | A matching entry denies this access |
| pa | output | 32 | Translated physical address, zero unless hit |
| attr | output | 4 | {write-through, inhibit, coherent, guarded}, zero unless hit |

## Verification
The bench probes addresses one byte inside and one byte beyond a 128 KB block. A design that applied the mask at the wrong bit offset, or left the block index unmasked, would hit or miss on the wrong side of that edge. Two overlapping entries are given different outputs and then switched on and off. This exposes a reversed priority order or merged results. Each privilege level is tried against an entry that is valid for only the other level, and writes and fetches are aimed at read-only, no-access and code-3 entries. Swapped valid bits, a fault that does not suppress the hit, or a guarded bit leaking onto a fetch would each change a checked output.

// File: rtl/bat_pkg.sv
// Shared widths, access encoding and the stored entry layout for the
// block address translator. Assumes 32-bit addresses and a smallest block
// of 128 KB, so the block index is the top 15 address bits.
package bat_pkg;
    localparam int ADDR_W   = 32;
    localparam int OFF_W    = 17;
    localparam int IDX_W    = ADDR_W - OFF_W;
    localparam int MASK_W   = 11;
    localparam int ATTR_W   = 4;
    localparam int PROT_W   = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_e;

    typedef struct packed {
        logic [IDX_W-1:0]  eidx;
        logic [MASK_W-1:0] mask;
        logic              sv;
        logic              uv;
        logic [IDX_W-1:0]  pidx;
        logic [ATTR_W-1:0] attr;
        logic [PROT_W-1:0] prot;
    } bat_ent_t;

    // Widen the length mask to the block index width (upper bits never masked).
    function automatic logic [IDX_W-1:0] widen_mask(input logic [MASK_W-1:0] m);
        return {{(IDX_W-MASK_W){1'b0}}, m};
    endfunction
endpackage

// File: rtl/bat_regs.sv
// Entry storage for the translator. Holds NUM_ENT entries, each loaded as
// an upper and a lower 32-bit word. Assumes wr_sel < NUM_ENT. Reset clears
// all fields, which leaves every entry invalid.
module bat_regs
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int SEL_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic                 wr_hi,
    input  logic [ADDR_W-1:0]    wr_data,
    output bat_ent_t             ent [NUM_ENT]
);
    logic unused_bits;
    assign unused_bits = ^{wr_data[OFF_W-1:MASK_W+2], wr_data[OFF_W-1:ATTR_W+3], wr_data[2]};

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        // Load one word of entry i when it is addressed, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[i] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(i)) begin
                if (wr_hi) begin
                    ent[i].eidx <= wr_data[ADDR_W-1:OFF_W];
                    ent[i].mask <= wr_data[MASK_W+1:2];
                    ent[i].sv   <= wr_data[1];
                    ent[i].uv   <= wr_data[0];
                end else begin
                    ent[i].pidx <= wr_data[ADDR_W-1:OFF_W];
                    ent[i].attr <= wr_data[ATTR_W+2:3];
                    ent[i].prot <= wr_data[PROT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/bat_match.sv
// Parallel comparators: one per entry, each checking the privilege-valid
// bit and the unmasked block index bits of the effective address.
module bat_match
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  bat_ent_t            ent [NUM_ENT],
    input  logic [IDX_W-1:0]    ea_idx,
    input  logic                user,
    output logic [NUM_ENT-1:0]  match
);
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
        logic priv_ok;
        logic [IDX_W-1:0] diff;
        // Pick the valid bit for the current privilege level.
        assign priv_ok  = user ? ent[i].uv : ent[i].sv;
        // Differences in bits covered by the mask do not count.
        assign diff     = (ea_idx ^ ent[i].eidx) & ~widen_mask(ent[i].mask);
        assign match[i] = priv_ok && (diff == '0);
    end
endmodule

// File: rtl/bat_select.sv
// Chooses the lowest-numbered matching entry, applies its protection code
// to the access kind and forms the physical address and attributes.
// Outputs are zero unless the access is both matched and permitted.
module bat_select
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  bat_ent_t             ent [NUM_ENT],
    input  logic [NUM_ENT-1:0]   match,
    input  logic [ADDR_W-1:0]    ea,
    input  logic [1:0]           acc,
    output logic                 hit,
    output logic                 fault,
    output logic [ADDR_W-1:0]    pa,
    output logic [ATTR_W-1:0]    attr
);
    logic             found;
    bat_ent_t         win;
    logic             allowed;
    logic [IDX_W-1:0] m;
    logic [IDX_W-1:0] pa_idx;

    // Priority pick: the first matching entry from index 0 upward.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (match[i] && !found) begin
                found = 1'b1;
                win   = ent[i];
            end
        end
    end

    // Protection: bit 1 grants all, bit 0 alone grants non-writes.
    assign allowed = win.prot[1] || (win.prot[0] && acc != ACC_WRITE);
    assign hit     = found && allowed;
    assign fault   = found && !allowed;

    // Address merge: masked positions come from the effective address.
    assign m      = widen_mask(win.mask);
    assign pa_idx = (win.pidx & ~m) | (ea[ADDR_W-1:OFF_W] & m);
    assign pa     = hit ? {pa_idx, ea[OFF_W-1:0]} : '0;

    // Attributes: guarded is not reported on the fetch side.
    assign attr = hit ? {win.attr[ATTR_W-1:1], win.attr[0] && (acc != ACC_FETCH)} : '0;
endmodule

// File: rtl/bat_xlate.sv
// Top of the block address translator. Storage, comparators and result
// selection are separate modules. The lookup path is combinational from
// ea/user/acc and the stored entries. Only writes are clocked.
module bat_xlate
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int SEL_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_hi,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       ea,
    input  logic              user,
    input  logic [1:0]        acc,
    output logic              hit,
    output logic              fault,
    output logic [31:0]       pa,
    output logic [3:0]        attr
);
    bat_ent_t            ent [NUM_ENT];
    logic [NUM_ENT-1:0]  match;

    bat_regs #(.NUM_ENT(NUM_ENT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_hi(wr_hi), .wr_data(wr_data), .ent(ent)
    );

    bat_match #(.NUM_ENT(NUM_ENT)) u_match (
        .ent(ent), .ea_idx(ea[ADDR_W-1:OFF_W]), .user(user), .match(match)
    );

    bat_select #(.NUM_ENT(NUM_ENT)) u_sel (
        .ent(ent), .match(match), .ea(ea), .acc(acc),
        .hit(hit), .fault(fault), .pa(pa), .attr(attr)
    );
endmodule

// File: rtl/bat_xlate_chk.sv
// Port-level checker for bat_xlate, attached with bind below.
module bat_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ea,
    input logic [1:0]  acc,
    input logic        hit,
    input logic        fault,
    input logic [31:0] pa,
    input logic [3:0]  attr
);
    // R7: a fault never comes with a hit
    p_fault_excl_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && fault));

    // R9: no hit means zero address and attributes
    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pa == 32'd0 && attr == 4'd0));

    // R5: in-block offset passes through unchanged
    p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa[16:0] == ea[16:0]));

    // R8: fetch never reports guarded
    p_fetch_unguarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && acc == 2'd2) |-> !attr[0]);

    // R1: first cycle after reset has no translation result
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!hit && !fault));
endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ea(ea), .acc(acc),
    .hit(hit), .fault(fault), .pa(pa), .attr(attr)
);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ea = '0;
    logic        user = 1'b0;
    logic [1:0]  acc = '0;
    logic        hit, fault;
    logic [31:0] pa;
    logic [3:0]  attr;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bat_xlate uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
        .wr_data(wr_data), .ea(ea), .user(user), .acc(acc),
        .hit(hit), .fault(fault), .pa(pa), .attr(attr)
    );

    typedef struct packed {
        logic [31:0] ea;
        logic        user;
        logic [1:0]  acc;
        logic        hit;
        logic        flt;
        logic [31:0] pa;
        logic [3:0]  attr;
    } vec_t;

    // Entries: 0 = 128K at 0x00020000 -> 0x02000000, supervisor only, RW, W
    //          1 = 16M at 0x10000000 -> 0x40000000, both, RO, I+G
    //          2 = 128K at 0x10000000 -> 0x60000000, both, RW, M (shadowed by 1)
    //          3 = 256M at 0x20000000 -> 0x80000000, user only, no access
    localparam vec_t TBL [12] = '{
        '{32'h0002_1234, 1'b0, 2'd0, 1'b1, 1'b0, 32'h0200_1234, 4'h8}, // R3 R5
        '{32'h0002_1234, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0,         4'h0}, // R4
        '{32'h0003_FFFF, 1'b0, 2'd1, 1'b1, 1'b0, 32'h0201_FFFF, 4'h8}, // R3 edge
        '{32'h0004_0000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         4'h0}, // R3 R9
        '{32'h10AB_CDEF, 1'b1, 2'd0, 1'b1, 1'b0, 32'h40AB_CDEF, 4'h5}, // R5 R8
        '{32'h10AB_CDEF, 1'b0, 2'd1, 1'b0, 1'b1, 32'h0,         4'h0}, // R7
        '{32'h1000_0010, 1'b1, 2'd2, 1'b1, 1'b0, 32'h4000_0010, 4'h4}, // R6 R8
        '{32'h1100_0000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         4'h0}, // R3
        '{32'h2345_6789, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0,         4'h0}, // R7
        '{32'h2345_6789, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         4'h0}, // R4
        '{32'h2FFF_FFFC, 1'b1, 2'd2, 1'b0, 1'b1, 32'h0,         4'h0}, // R3 R7
        '{32'h0002_0000, 1'b0, 2'd2, 1'b1, 1'b0, 32'h0200_0000, 4'h8}  // R8
    };

    task automatic wr(input logic [1:0] s, input logic hi, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string tag, input logic [31:0] a, input logic u,
                        input logic [1:0] k, input logic eh, input logic ef,
                        input logic [31:0] ep, input logic [3:0] eat);
        ea = a; user = u; acc = k;
        #1;
        n_chk++;
        if (hit !== eh || fault !== ef || pa !== ep || attr !== eat) begin
            n_bad++;
            $display("FAIL %s ea=%h: got hit=%b fault=%b pa=%h attr=%h exp hit=%b fault=%b pa=%h attr=%h",
                     tag, a, hit, fault, pa, attr, eh, ef, ep, eat);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        look("R1", 32'h0002_0000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 4'h0);
        look("R1", 32'h2000_0000, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 4'h0);
        // R2: load entries through the write port
        wr(2'd0, 1'b1, 32'h0002_0002); wr(2'd0, 1'b0, 32'h0200_0042);
        wr(2'd1, 1'b1, 32'h1000_01FF); wr(2'd1, 1'b0, 32'h4000_0029);
        wr(2'd2, 1'b1, 32'h1000_0003); wr(2'd2, 1'b0, 32'h6000_0012);
        wr(2'd3, 1'b1, 32'h2000_1FFD); wr(2'd3, 1'b0, 32'h8000_0000);
        for (int i = 0; i < 12; i++) begin
            look("R2-table", TBL[i].ea, TBL[i].user, TBL[i].acc, TBL[i].hit,
                 TBL[i].flt, TBL[i].pa, TBL[i].attr);
        end
        // R6: invalidate entry 1, entry 2 now decides
        wr(2'd1, 1'b1, 32'h1000_01FC);
        look("R6", 32'h1000_0010, 1'b1, 2'd0, 1'b1, 1'b0, 32'h6000_0010, 4'h2);
        look("R6", 32'h10AB_CDEF, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 4'h0);
        // R7: protection code 3 allows writes
        wr(2'd0, 1'b0, 32'h0200_0043);
        look("R7", 32'h0002_0010, 1'b0, 2'd1, 1'b1, 1'b0, 32'h0200_0010, 4'h8);
        // R7: access kind 3 behaves as read on a read-only block
        wr(2'd1, 1'b1, 32'h1000_01FF);
        look("R7", 32'h1000_4000, 1'b0, 2'd3, 1'b1, 1'b0, 32'h4000_4000, 4'h5);
        // R1: reset in mid-run clears all entries
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look("R1", 32'h0002_0010, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 4'h0);
        look("R1", 32'h2345_6789, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 4'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule